// File: doc/BRIEF.md
# UART FIFO Control with Receive Trigger

This block holds the write-only FIFO control word of a UART and the two byte queues that word governs: a transmit queue fed by the bus and drained by an external transmit shifter, and a receive queue filled by an external receive shifter and drained by the bus. One control write can do three things. It can switch between queued operation and single-byte holding operation. It can empty either queue. It can choose how full the receive queue must be before the block raises a receive interrupt condition and a receive DMA request.

Each receive entry carries the data byte together with its parity, framing and break flags. A summary output is high while any stored entry has a flag set. Separate sticky line-error flags record overrun, parity, framing and break events. They survive queue flushes and clear only on an explicit clear pulse. Interrupt prioritisation, bus decode and the shifters themselves sit outside the block and connect through plain pins.

Byte traffic uses valid/ready. On `tx_in` and `rx_out` a byte moves on a clock edge where valid and ready are both high. A source may hold valid high while ready is low, and the data must stay stable during that wait. `tx_in_ready` is low while the transmit queue is at capacity. `tx_out_valid` and `rx_out_valid` are high while the queue holds a byte, and the head byte stays put until it is taken. The receive input has no ready: a byte offered while the receive queue is at capacity is lost and recorded as an overrun.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the block is in single-byte mode with trigger code 00. Both queues are empty, `tx_req` is 1, and `rx_irq`, `rx_dma_req`, `fifo_err` and `line_err` are 0.
- R2: A control write with bit 0 = 0 selects single-byte mode and empties both queues, whatever the other bits hold. A write with bit 0 = 1 selects queued mode. A write that changes the mode empties both queues.
- R3: Bits 7:6 of a write with bit 0 = 1 set the trigger level: 00 means 1 byte, 01 means 8, 10 means 16 and 11 means 32. In queued mode, `rx_irq` is high when `rx_count` is at or above the level and `rx_int_en` is 1, and low otherwise.
- R4: In queued mode, `rx_dma_req` is high when `rx_count` is at or above the level and the code is not 00. It is never high with code 00 or in single-byte mode.
- R5: A write with bits 0 and 1 both set empties the receive queue. After the write, `data_ready`, `fifo_err` and `rx_irq` read 0.
- R6: `line_err` = {break, framing, parity, overrun} (bit 3 down to bit 0). Each bit is sticky. Flushes leave all four bits unchanged, and only a pulse on `line_err_clr` clears them.
- R7: A write with bits 0 and 2 both set empties the transmit queue. `tx_req` then reads 1, and `tx_irq` reads 1 when `tx_int_en` is 1. The receive queue is unaffected.
- R8: A 0 in bit 1 or bit 2 flushes nothing. Flush requests are not stored, so a later write without them leaves both queues intact.
- R9: In single-byte mode each direction holds one byte. `tx_in_ready` is 0 once a byte is held, and `rx_irq` follows any held byte while `rx_int_en` is 1.
- R10: The receive queue holds 64 entries in queued mode. A byte offered at capacity is dropped, `rx_count` does not change, and `line_err[0]` is set.
- R11: The receive queue returns bytes in arrival order. `rx_out_flags` is {break, framing, parity} (bit 2 down to bit 0), and `fifo_err` is high exactly while a stored entry has a flag set.
- R12: The transmit queue accepts 64 bytes in queued mode, after which `tx_in_ready` is 0. Bytes leave on `tx_out` in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 8 | Control word |
| rx_int_en | input | 1 | Receive-data interrupt enable |
| tx_int_en | input | 1 | Transmit-request interrupt enable |
| line_err_clr | input | 1 | Clears the sticky line-error flags |
| tx_in_valid | input | 1 | Bus offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue can take a byte |
| tx_in_data | input | 8 | Transmit byte from the bus |
| tx_out_valid | output | 1 | Transmit byte available for the shifter |
| tx_out_ready | input | 1 | Shifter takes the byte |
| tx_out_data | output | 8 | Transmit byte to the shifter |
| rx_in_valid | input | 1 | Shifter delivers a received byte |
| rx_in_data | input | 8 | Received byte |
| rx_in_flags | input | 3 | {break, framing, parity} for the received byte |
| rx_out_valid | output | 1 | Receive byte available for the bus |
| rx_out_ready | input | 1 | Bus takes the byte |
| rx_out_data | output | 8 | Head receive byte |
| rx_out_flags | output | 3 | Flags of the head receive byte |
| fifo_mode | output | 1 | 1 in queued mode |
| rx_count | output | 7 | Receive queue occupancy |
| tx_count | output | 7 | Transmit queue occupancy |
| data_ready | output | 1 | Receive queue is not empty |
| fifo_err | output | 1 | A stored receive entry carries an error flag |
| line_err | output | 4 | Sticky {break, framing, parity, overrun} |
| tx_req | output | 1 | Transmit queue is empty |
| tx_irq | output | 1 | Transmit-request interrupt condition |
| rx_irq | output | 1 | Receive-data-available interrupt condition |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block with its defaults: 8-bit data and 64-entry queues. At that depth, each of the thresholds at 1, 8 and 32 bytes can be crossed by a one-byte step. Filling the receive queue to capacity and offering one byte more checks the overrun boundary within a few hundred cycles. The same depth lets the transmit queue be driven to its full, back-pressured state.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  // control word bit positions
  localparam int CTL_EN      = 0;
  localparam int CTL_RXFL    = 1;
  localparam int CTL_TXFL    = 2;
  localparam int CTL_TRIG_LO = 6;
  localparam int CTL_TRIG_HI = 7;

  // receive thresholds in bytes
  localparam int LVL_A = 1;
  localparam int LVL_B = 8;
  localparam int LVL_C = 16;
  localparam int LVL_D = 32;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_EGT  = 2'b01,
    TRIG_SXT  = 2'b10,
    TRIG_TTW  = 2'b11
  } trig_e;
endpackage

// File: rtl/uart_fifo_ctl_reg.sv
module uart_fifo_ctl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       fifo_mode,
  output trig_e      trig,
  output logic       rx_flush,
  output logic       tx_flush
);
  logic en;
  logic unused_rsvd;

  assign en          = wdata[CTL_EN];
  assign unused_rsvd = &{1'b0, wdata[5:3]};

  // flushes are actions, never stored
  assign rx_flush = wr & (~en | wdata[CTL_RXFL] | ~fifo_mode);
  assign tx_flush = wr & (~en | wdata[CTL_TXFL] | ~fifo_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_mode <= 1'b0;
      trig      <= TRIG_ONE;
    end else if (wr) begin
      fifo_mode <= en;
      if (en) trig <= trig_e'(wdata[CTL_TRIG_HI:CTL_TRIG_LO]);
    end
  end

  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[CTL_EN]) |=> !fifo_mode);

  // R2
  mode_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[CTL_EN]) |=> fifo_mode);
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          push, pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign cap       = single ? CW'(1) : CW'(DEPTH);
  assign in_ready  = (count < cap);
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid & in_ready & ~flush;
  assign pop       = out_valid & out_ready & ~flush;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R9
  single_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single && count != '0) |-> !in_ready);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_fifo_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  trig_e         trig,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          rx_ie,
  input  logic          tx_ie,
  input  logic          rx_flush,
  input  logic          err_clr,
  input  logic          push,
  input  logic [2:0]    push_flags,
  input  logic          pop,
  input  logic [2:0]    pop_flags,
  input  logic          drop,
  output logic          rx_irq,
  output logic          rx_dma_req,
  output logic          tx_req,
  output logic          tx_irq,
  output logic          data_ready,
  output logic          fifo_err,
  output logic [3:0]    line_err
);
  logic [CW-1:0] err_cnt;
  logic [CW-1:0] lvl;
  logic          reached;
  logic [3:0]    events;

  always_comb begin
    case (trig)
      TRIG_ONE: lvl = CW'(LVL_A);
      TRIG_EGT: lvl = CW'(LVL_B);
      TRIG_SXT: lvl = CW'(LVL_C);
      default:  lvl = CW'(LVL_D);
    endcase
  end

  assign reached    = fifo_mode ? (rx_count >= lvl) : (rx_count != '0);
  assign rx_irq     = rx_ie & reached;
  assign rx_dma_req = fifo_mode & (trig != TRIG_ONE) & reached;
  assign tx_req     = (tx_count == '0);
  assign tx_irq     = tx_ie & tx_req;
  assign data_ready = (rx_count != '0);
  assign fifo_err   = (err_cnt != '0);

  // entries in the queue that carry any flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_cnt <= '0;
    else if (rx_flush) err_cnt <= '0;
    else               err_cnt <= err_cnt + CW'(push & (|push_flags))
                                          - CW'(pop & (|pop_flags));
  end

  assign events = {push & push_flags[2], push & push_flags[1],
                   push & push_flags[0], drop};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_err <= '0;
    else        line_err <= (err_clr ? 4'b0 : line_err) | events;
  end

  // R4
  dma_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (rx_count >= CW'(LVL_B)));

  // R6
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush && !err_clr && !push && !drop) |=> $stable(line_err));

  // R11
  err_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err |-> (rx_count != '0));

  // R5
  flush_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !fifo_err);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          rx_int_en,
  input  logic          tx_int_en,
  input  logic          line_err_clr,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  input  logic [DW-1:0] rx_in_data,
  input  logic [2:0]    rx_in_flags,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  output logic [2:0]    rx_out_flags,
  output logic          fifo_mode,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          data_ready,
  output logic          fifo_err,
  output logic [3:0]    line_err,
  output logic          tx_req,
  output logic          tx_irq,
  output logic          rx_irq,
  output logic          rx_dma_req
);
  localparam int RW = DW + 3;

  trig_e         trig;
  logic          rx_flush, tx_flush;
  logic          rx_room, rx_push, rx_pop, rx_drop;
  logic [RW-1:0] rx_head;

  uart_fifo_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctl_wr),
    .wdata     (ctl_wdata),
    .fifo_mode (fifo_mode),
    .trig      (trig),
    .rx_flush  (rx_flush),
    .tx_flush  (tx_flush)
  );

  uart_byte_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .single    (~fifo_mode),
    .in_valid  (tx_in_valid),
    .in_data   (tx_in_data),
    .in_ready  (tx_in_ready),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_data),
    .count     (tx_count)
  );

  uart_byte_fifo #(.W(RW), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .single    (~fifo_mode),
    .in_valid  (rx_in_valid),
    .in_data   ({rx_in_flags, rx_in_data}),
    .in_ready  (rx_room),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_head),
    .count     (rx_count)
  );

  assign rx_out_data  = rx_head[DW-1:0];
  assign rx_out_flags = rx_head[RW-1:DW];
  assign rx_push      = rx_in_valid & rx_room;
  assign rx_drop      = rx_in_valid & ~rx_room;
  assign rx_pop       = rx_out_valid & rx_out_ready;

  uart_rx_status #(.CW(CW)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_mode  (fifo_mode),
    .trig       (trig),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .rx_ie      (rx_int_en),
    .tx_ie      (tx_int_en),
    .rx_flush   (rx_flush),
    .err_clr    (line_err_clr),
    .push       (rx_push),
    .push_flags (rx_in_flags),
    .pop        (rx_pop),
    .pop_flags  (rx_out_flags),
    .drop       (rx_drop),
    .rx_irq     (rx_irq),
    .rx_dma_req (rx_dma_req),
    .tx_req     (tx_req),
    .tx_irq     (tx_irq),
    .data_ready (data_ready),
    .fifo_err   (fifo_err),
    .line_err   (line_err)
  );

  // R10
  drop_marks_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !line_err_clr) |=> line_err[0]);

  // R7
  tx_flush_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_req);
endmodule

// File: tb/uart_fifo_ctl_bench.sv
module uart_fifo_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       rx_int_en = 1'b0, tx_int_en = 1'b0, line_err_clr = 1'b0;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] rx_in_data = '0;
  logic [2:0] rx_in_flags = '0;
  logic       tx_in_ready, tx_out_valid, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data;
  logic [2:0] rx_out_flags;
  logic       fifo_mode, data_ready, fifo_err, tx_req, tx_irq, rx_irq, rx_dma_req;
  logic [6:0] rx_count, tx_count;
  logic [3:0] line_err;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_fifo_ctl u_uart_fifo_ctl (.*);

  task automatic chk(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] d, input logic [2:0] f);
    @(negedge clk); rx_in_valid = 1'b1; rx_in_data = d; rx_in_flags = f;
    @(negedge clk); rx_in_valid = 1'b0; rx_in_flags = '0;
  endtask

  task automatic rx_take(output logic [7:0] d, output logic [2:0] f);
    @(negedge clk); d = rx_out_data; f = rx_out_flags; rx_out_ready = 1'b1;
    @(negedge clk); rx_out_ready = 1'b0;
  endtask

  task automatic tx_put(input logic [7:0] d, output bit took);
    @(negedge clk); tx_in_valid = 1'b1; tx_in_data = d; took = tx_in_ready;
    @(negedge clk); tx_in_valid = 1'b0;
  endtask

  task automatic clr_err();
    @(negedge clk); line_err_clr = 1'b1;
    @(negedge clk); line_err_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", fifo_mode, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 tx_req", tx_req, 1);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 dma", rx_dma_req, 0);
    chk("R1 fifo_err", fifo_err, 0);
    chk("R1 line_err", line_err, 0);
  endtask

  task automatic t_trig8();
    rx_int_en = 1'b1;
    wr_ctl(8'h41);
    chk("R2 mode on", fifo_mode, 1);
    for (int i = 0; i < 7; i++) rx_put(8'(i), 3'b000);
    chk("R3 irq below 8", rx_irq, 0);
    chk("R4 dma below 8", rx_dma_req, 0);
    rx_put(8'h07, 3'b000);
    chk("R3 irq at 8", rx_irq, 1);
    chk("R4 dma at 8", rx_dma_req, 1);
    @(negedge clk); rx_int_en = 1'b0;
    #1 chk("R3 irq masked", rx_irq, 0);
    rx_int_en = 1'b1;
    wr_ctl(8'h03);
    chk("R5 flushed", rx_count, 0);
  endtask

  task automatic t_trig1();
    wr_ctl(8'h01);
    rx_put(8'hA5, 3'b000);
    chk("R3 irq code00", rx_irq, 1);
    chk("R4 no dma code00", rx_dma_req, 0);
    wr_ctl(8'h03);
  endtask

  task automatic t_trig32();
    wr_ctl(8'hC1);
    for (int i = 0; i < 31; i++) rx_put(8'(i), 3'b000);
    chk("R3 irq at 31", rx_irq, 0);
    chk("R4 dma at 31", rx_dma_req, 0);
    rx_put(8'h1F, 3'b000);
    chk("R3 irq at 32", rx_irq, 1);
    chk("R4 dma at 32", rx_dma_req, 1);
    wr_ctl(8'h03);
  endtask

  task automatic t_rxflush();
    bit took;
    wr_ctl(8'h01);
    rx_put(8'h10, 3'b001);
    rx_put(8'h11, 3'b000);
    tx_put(8'h20, took);
    tx_put(8'h21, took);
    chk("R11 fifo_err set", fifo_err, 1);
    chk("R6 parity sticky", line_err, 4'b0010);
    wr_ctl(8'h03);
    chk("R5 rx empty", rx_count, 0);
    chk("R5 data_ready", data_ready, 0);
    chk("R5 fifo_err", fifo_err, 0);
    chk("R5 rx_irq", rx_irq, 0);
    chk("R6 sticky kept", line_err, 4'b0010);
    chk("R5 tx kept", tx_count, 2);
  endtask

  task automatic t_txflush();
    tx_int_en = 1'b1;
    rx_put(8'h33, 3'b000);
    chk("R7 tx_req busy", tx_req, 0);
    chk("R7 tx_irq busy", tx_irq, 0);
    wr_ctl(8'h05);
    chk("R7 tx empty", tx_count, 0);
    chk("R7 tx_req", tx_req, 1);
    chk("R7 tx_irq", tx_irq, 1);
    chk("R7 rx kept", rx_count, 1);
    tx_int_en = 1'b0;
  endtask

  task automatic t_zeroflush();
    bit took;
    tx_put(8'h44, took);
    wr_ctl(8'h01);
    chk("R8 rx kept", rx_count, 1);
    chk("R8 tx kept", tx_count, 1);
    wr_ctl(8'h41);
    chk("R8 not stored rx", rx_count, 1);
    chk("R8 not stored tx", tx_count, 1);
    @(negedge clk); tx_out_ready = 1'b1;
    #1 chk("R12 tx head", tx_out_data, 8'h44);
    @(negedge clk); tx_out_ready = 1'b0;
    wr_ctl(8'h03);
  endtask

  task automatic t_order();
    logic [7:0] d; logic [2:0] f;
    wr_ctl(8'h01);
    rx_put(8'h11, 3'b000);
    rx_put(8'h22, 3'b010);
    rx_put(8'h33, 3'b100);
    chk("R11 err summary", fifo_err, 1);
    rx_take(d, f);
    chk("R11 data0", d, 8'h11); chk("R11 flags0", f, 0);
    rx_take(d, f);
    chk("R11 data1", d, 8'h22); chk("R11 flags1", f, 3'b010);
    chk("R11 err still", fifo_err, 1);
    rx_take(d, f);
    chk("R11 data2", d, 8'h33); chk("R11 flags2", f, 3'b100);
    chk("R11 err gone", fifo_err, 0);
    chk("R6 sticky bits", line_err, 4'b1110);
    clr_err();
    chk("R6 cleared", line_err, 0);
  endtask

  task automatic t_single();
    bit took;
    logic [7:0] d; logic [2:0] f;
    rx_put(8'h55, 3'b000);
    tx_put(8'h66, took);
    wr_ctl(8'hC6);
    chk("R2 mode off", fifo_mode, 0);
    chk("R2 rx emptied", rx_count, 0);
    chk("R2 tx emptied", tx_count, 0);
    rx_put(8'hA1, 3'b000);
    chk("R9 one held", rx_count, 1);
    chk("R9 irq any byte", rx_irq, 1);
    chk("R4 no dma single", rx_dma_req, 0);
    rx_put(8'hA2, 3'b000);
    chk("R10 dropped", rx_count, 1);
    chk("R10 overrun", line_err, 4'b0001);
    rx_take(d, f);
    chk("R9 kept first", d, 8'hA1);
    tx_put(8'hB1, took);
    chk("R9 tx first took", took, 1);
    tx_put(8'hB2, took);
    chk("R9 tx second refused", took, 0);
    chk("R9 tx_in_ready", tx_in_ready, 0);
    rx_put(8'hA3, 3'b000);
    wr_ctl(8'h01);
    chk("R2 switch empties rx", rx_count, 0);
    chk("R2 switch empties tx", tx_count, 0);
    clr_err();
  endtask

  task automatic t_full();
    bit took;
    wr_ctl(8'h01);
    for (int i = 0; i < 64; i++) rx_put(8'(i), 3'b000);
    chk("R10 full count", rx_count, 64);
    chk("R10 no overrun yet", line_err, 0);
    rx_put(8'hFF, 3'b000);
    chk("R10 count held", rx_count, 64);
    chk("R10 overrun", line_err, 4'b0001);
    for (int i = 0; i < 64; i++) tx_put(8'(i), took);
    chk("R12 tx full", tx_count, 64);
    chk("R12 tx back-pressure", tx_in_ready, 0);
    @(negedge clk); tx_out_ready = 1'b1;
    #1 chk("R12 tx order", tx_out_data, 0);
    @(negedge clk); tx_out_ready = 1'b0;
    chk("R12 ready again", tx_in_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trig8();
    t_trig1();
    t_trig32();
    t_rxflush();
    t_txflush();
    t_zeroflush();
    t_order();
    t_single();
    t_full();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule